// File: doc/BRIEF.md
# Performance Monitor User-Access Control: System Register Access Trap Decoder

This block decides what happens when software tries to read or write the privileged control register that sets which performance counters user code may touch. A request strobe carries the current exception level, the direction, the five-field system instruction encoding and a snapshot of the trap and enable controls held at the higher levels. The decoder checks the encoding first. It then runs a priority chain that depends on the level, and picks one outcome: the access is undefined, it traps to EL2, it traps to EL3, or it is allowed. An encoding that is not this register gives a separate miss indication.

The decision is held in a small state machine. Its states are ST_IDLE (after reset), ST_UNDEF, ST_TRAP2, ST_TRAP3, ST_PERMIT and ST_MISS. There is one transition rule. On a cycle with the strobe high, the machine moves from any state to the state for the outcome just decoded. Without the strobe it stays where it is. With `REGISTERED=1` (the default) the outputs follow the state register, so they appear one cycle after the strobe. With `REGISTERED=0` they follow the decoded outcome in the strobe cycle itself and then hold it. Trap outcomes also report a 6-bit exception class.

Top module: `perfmon_uacc_trap_dec`

## Requirements
- R1: The register is selected only by op0=2'b11, op1=3'b000, CRn=4'b1001, CRm=4'b1110, op2=3'b100, for reads and writes alike. Any other encoding raises `out_nomatch` and none of the four outcomes, with `out_syn_class` equal to 0.
- R2: A matching access from level 0 is undefined.
- R3: A matching access from level 3 is always permitted, whatever the control inputs are.
- R4: At levels 1 and 2 the access is undefined when three things hold: EL3 is present, `sdd_undef_prio` is 1, and either `el3_pm_en` is 0 or `el3_pm_trap` is 1. This check wins over every other check.
- R5: At level 1 only, when EL2 is enabled and the fine-grained feature is present, the access traps to EL2 in two cases. The first is that EL3 is present with `el3_fgt_en` at 0. The second is that the active-low fine-grained bit for the direction is 0: `fgt_rd_n` for reads, `fgt_wr_n` for writes.
- R6: At level 1 only, and after R5, an enabled EL2 with `el2_pm_trap` at 1 traps the access to EL2.
- R7: At levels 1 and 2, and after R4 to R6, EL3 present with `el3_pm_en` at 0 or `el3_pm_trap` at 1 gives one of two outcomes. The access is undefined if `sdd_undef` is 1. Otherwise it traps to EL3.
- R8: A matching access at level 1 or 2 that none of R4 to R7 catches is permitted.
- R9: `out_syn_class` is 6'h18 while a trap outcome (to EL2 or to EL3) is shown, and 0 otherwise.
- R10: In the registered build, the outcome appears in the cycle after a strobe. Exactly one of the five result outputs is high, and all outputs hold until the next strobe, whatever the inputs do in between.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_el | input | 2 | Current exception level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cfg_el2_en | input | 1 | EL2 is enabled for the current state |
| cfg_el3_present | input | 1 | EL3 is implemented |
| cfg_fgt_present | input | 1 | Fine-grained trap feature is implemented |
| el3_fgt_en | input | 1 | EL3 enable for the fine-grained traps |
| el3_pm_en | input | 1 | EL3 performance monitor enable |
| el3_pm_trap | input | 1 | EL3 performance monitor trap |
| el2_pm_trap | input | 1 | EL2 performance monitor trap |
| fgt_rd_n | input | 1 | Active-low fine-grained read trap bit |
| fgt_wr_n | input | 1 | Active-low fine-grained write trap bit |
| sdd_undef_prio | input | 1 | Secure-debug undefined takes top priority |
| sdd_undef | input | 1 | Secure-debug turns EL3 traps into undefined |
| out_undef | output | 1 | Access is undefined |
| out_trap_el2 | output | 1 | Access traps to EL2 |
| out_trap_el3 | output | 1 | Access traps to EL3 |
| out_permit | output | 1 | Access is permitted |
| out_nomatch | output | 1 | Encoding is not this register |
| out_syn_class | output | 6 | Exception class on traps |

## Verification
The bench builds the block with its default parameters. That means the registered response, exception class 6'h18 and the register's own encoding. In this build every outcome lands exactly one cycle after its strobe, so a behavioural model can be compared against the ports on every clock, including the idle stretches in which the inputs are scrambled to test holding. Directed requests put two or more checks against each other at once, such as a secure-debug priority condition together with a fine-grained trap. Randomised requests with single-bit encoding misses then cover the rest of the flag space.

// File: rtl/uatd_pkg.sv
package uatd_pkg;

    localparam int OP0_W = 2;
    localparam int OP1_W = 3;
    localparam int CRN_W = 4;
    localparam int CRM_W = 4;
    localparam int OP2_W = 3;
    localparam int SYN_W = 6;
    localparam int NUM_RESULTS = 5;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } level_e;

    typedef enum logic [2:0] {
        OC_NONE     = 3'd0,
        OC_UNDEF    = 3'd1,
        OC_TRAP_EL2 = 3'd2,
        OC_TRAP_EL3 = 3'd3,
        OC_PERMIT   = 3'd4,
        OC_NOMATCH  = 3'd5
    } outcome_e;

    typedef struct packed {
        logic [OP0_W-1:0] op0;
        logic [OP1_W-1:0] op1;
        logic [CRN_W-1:0] crn;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } sys_enc_t;

    typedef struct packed {
        logic el2_en;
        logic el3_present;
        logic fgt_present;
    } impl_t;

    typedef struct packed {
        logic fgt_en;
        logic pm_en;
        logic pm_trap;
    } l3ctl_t;

    typedef struct packed {
        logic prio;
        logic undef;
    } sdd_t;

endpackage

// File: rtl/uatd_enc_match.sv
module uatd_enc_match
    import uatd_pkg::*;
#(
    parameter logic [OP0_W-1:0] M_OP0 = 2'b11,
    parameter logic [OP1_W-1:0] M_OP1 = 3'b000,
    parameter logic [CRN_W-1:0] M_CRN = 4'b1001,
    parameter logic [CRM_W-1:0] M_CRM = 4'b1110,
    parameter logic [OP2_W-1:0] M_OP2 = 3'b100
) (
    input  sys_enc_t enc,
    output logic     hit
);

    localparam int NFIELD = 5;
    localparam int ENC_W  = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;
    localparam sys_enc_t TARGET = '{op0: M_OP0, op1: M_OP1, crn: M_CRN,
                                    crm: M_CRM, op2: M_OP2};

    logic [NFIELD-1:0] field_ok;
    logic [ENC_W-1:0]  bit_ok;

    // per-bit comparison against the fixed target encoding
    genvar gi;
    generate
        for (gi = 0; gi < ENC_W; gi++) begin : g_bit
            assign bit_ok[gi] = (enc[gi] == TARGET[gi]);
        end
    endgenerate

    // fold bits into the five fields (op2 in the low bits)
    localparam int LO_OP2 = 0;
    localparam int LO_CRM = LO_OP2 + OP2_W;
    localparam int LO_CRN = LO_CRM + CRM_W;
    localparam int LO_OP1 = LO_CRN + CRN_W;
    localparam int LO_OP0 = LO_OP1 + OP1_W;

    assign field_ok[0] = &bit_ok[LO_OP2 +: OP2_W];
    assign field_ok[1] = &bit_ok[LO_CRM +: CRM_W];
    assign field_ok[2] = &bit_ok[LO_CRN +: CRN_W];
    assign field_ok[3] = &bit_ok[LO_OP1 +: OP1_W];
    assign field_ok[4] = &bit_ok[LO_OP0 +: OP0_W];

    assign hit = &field_ok;

endmodule

// File: rtl/uatd_prio_chain.sv
module uatd_prio_chain
    import uatd_pkg::*;
(
    input  logic     enc_hit,
    input  level_e   lvl,
    input  logic     is_write,
    input  impl_t    impl,
    input  l3ctl_t   l3,
    input  logic     el2_pm_trap,
    input  logic     fgt_rd_n,
    input  logic     fgt_wr_n,
    input  sdd_t     sdd,
    output outcome_e verdict
);

    logic el3_blocks;
    logic fgt_dir_n;
    logic fgt_catch;
    logic l2_catch;
    outcome_e el3_result;
    outcome_e low_chain;

    // EL3 gate: enable cleared or trap set
    assign el3_blocks = impl.el3_present && (!l3.pm_en || l3.pm_trap);
    assign fgt_dir_n  = is_write ? fgt_wr_n : fgt_rd_n;
    assign fgt_catch  = impl.el2_en && impl.fgt_present &&
                        ((impl.el3_present && !l3.fgt_en) || !fgt_dir_n);
    assign l2_catch   = impl.el2_en && el2_pm_trap;
    assign el3_result = sdd.undef ? OC_UNDEF : OC_TRAP_EL3;

    // tail of the chain shared by levels 1 and 2
    always_comb begin
        if (el3_blocks) begin
            low_chain = el3_result;
        end else begin
            low_chain = OC_PERMIT;
        end
    end

    always_comb begin
        verdict = OC_NOMATCH;
        if (enc_hit) begin
            unique case (lvl)
                LVL_0: verdict = OC_UNDEF;
                LVL_1: begin
                    if (el3_blocks && sdd.prio) begin
                        verdict = OC_UNDEF;
                    end else if (fgt_catch) begin
                        verdict = OC_TRAP_EL2;
                    end else if (l2_catch) begin
                        verdict = OC_TRAP_EL2;
                    end else begin
                        verdict = low_chain;
                    end
                end
                LVL_2: begin
                    if (el3_blocks && sdd.prio) begin
                        verdict = OC_UNDEF;
                    end else begin
                        verdict = low_chain;
                    end
                end
                LVL_3: verdict = OC_PERMIT;
                default: verdict = OC_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/uatd_resp_fsm.sv
module uatd_resp_fsm
    import uatd_pkg::*;
#(
    parameter bit               REGISTERED = 1'b1,
    parameter logic [SYN_W-1:0] SYN_CLASS  = 6'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  outcome_e         verdict,
    output logic             o_undef,
    output logic             o_trap2,
    output logic             o_trap3,
    output logic             o_permit,
    output logic             o_miss,
    output logic [SYN_W-1:0] o_syn
);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UNDEF  = 3'd1,
        ST_TRAP2  = 3'd2,
        ST_TRAP3  = 3'd3,
        ST_PERMIT = 3'd4,
        ST_MISS   = 3'd5
    } state_e;

    state_e state_q;
    state_e state_d;
    state_e state_now;
    state_e target;

    always_comb begin
        unique case (verdict)
            OC_UNDEF:    target = ST_UNDEF;
            OC_TRAP_EL2: target = ST_TRAP2;
            OC_TRAP_EL3: target = ST_TRAP3;
            OC_PERMIT:   target = ST_PERMIT;
            OC_NOMATCH:  target = ST_MISS;
            default:     target = ST_IDLE;
        endcase
    end

    // strobe moves to the decoded state, otherwise hold
    assign state_d = req_valid ? target : state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (REGISTERED) begin : g_reg
            assign state_now = state_q;
        end else begin : g_comb
            assign state_now = rst_n ? state_d : ST_IDLE;
        end
    endgenerate

    always_comb begin
        o_undef  = 1'b0;
        o_trap2  = 1'b0;
        o_trap3  = 1'b0;
        o_permit = 1'b0;
        o_miss   = 1'b0;
        o_syn    = '0;
        unique case (state_now)
            ST_IDLE:   ;
            ST_UNDEF:  o_undef = 1'b1;
            ST_TRAP2:  begin o_trap2 = 1'b1; o_syn = SYN_CLASS; end
            ST_TRAP3:  begin o_trap3 = 1'b1; o_syn = SYN_CLASS; end
            ST_PERMIT: o_permit = 1'b1;
            ST_MISS:   o_miss = 1'b1;
            default:   ;
        endcase
    end

    // R10: never two results at once
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_undef, o_trap2, o_trap3, o_permit, o_miss}));

    // R9: class present exactly while a trap is shown
    p_syn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_trap2 || o_trap3) == (o_syn == SYN_CLASS));

    generate
        if (REGISTERED) begin : g_reg_chk
            // R10: a strobe always yields exactly one result next cycle
            p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> ($countones({o_undef, o_trap2, o_trap3, o_permit, o_miss}) == 1));
            // R10: outputs hold while no strobe arrives
            p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |=> $stable({o_undef, o_trap2, o_trap3, o_permit, o_miss, o_syn}));
        end
    endgenerate

endmodule

// File: rtl/perfmon_uacc_trap_dec.sv
module perfmon_uacc_trap_dec
    import uatd_pkg::*;
#(
    parameter bit               REGISTERED = 1'b1,
    parameter logic [SYN_W-1:0] SYN_CLASS  = 6'h18,
    parameter logic [OP0_W-1:0] M_OP0      = 2'b11,
    parameter logic [OP1_W-1:0] M_OP1      = 3'b000,
    parameter logic [CRN_W-1:0] M_CRN      = 4'b1001,
    parameter logic [CRM_W-1:0] M_CRM      = 4'b1110,
    parameter logic [OP2_W-1:0] M_OP2      = 3'b100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_el,
    input  logic             req_write,
    input  logic [OP0_W-1:0] req_op0,
    input  logic [OP1_W-1:0] req_op1,
    input  logic [CRN_W-1:0] req_crn,
    input  logic [CRM_W-1:0] req_crm,
    input  logic [OP2_W-1:0] req_op2,
    input  logic             cfg_el2_en,
    input  logic             cfg_el3_present,
    input  logic             cfg_fgt_present,
    input  logic             el3_fgt_en,
    input  logic             el3_pm_en,
    input  logic             el3_pm_trap,
    input  logic             el2_pm_trap,
    input  logic             fgt_rd_n,
    input  logic             fgt_wr_n,
    input  logic             sdd_undef_prio,
    input  logic             sdd_undef,
    output logic             out_undef,
    output logic             out_trap_el2,
    output logic             out_trap_el3,
    output logic             out_permit,
    output logic             out_nomatch,
    output logic [SYN_W-1:0] out_syn_class
);

    sys_enc_t enc;
    impl_t    impl;
    l3ctl_t   l3;
    sdd_t     sdd;
    level_e   lvl;
    logic     enc_hit;
    outcome_e verdict;

    assign enc  = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign impl = '{el2_en: cfg_el2_en, el3_present: cfg_el3_present, fgt_present: cfg_fgt_present};
    assign l3   = '{fgt_en: el3_fgt_en, pm_en: el3_pm_en, pm_trap: el3_pm_trap};
    assign sdd  = '{prio: sdd_undef_prio, undef: sdd_undef};
    assign lvl  = level_e'(req_el);

    uatd_enc_match #(
        .M_OP0(M_OP0), .M_OP1(M_OP1), .M_CRN(M_CRN), .M_CRM(M_CRM), .M_OP2(M_OP2)
    ) u_match (
        .enc (enc),
        .hit (enc_hit)
    );

    uatd_prio_chain u_chain (
        .enc_hit     (enc_hit),
        .lvl         (lvl),
        .is_write    (req_write),
        .impl        (impl),
        .l3          (l3),
        .el2_pm_trap (el2_pm_trap),
        .fgt_rd_n    (fgt_rd_n),
        .fgt_wr_n    (fgt_wr_n),
        .sdd         (sdd),
        .verdict     (verdict)
    );

    uatd_resp_fsm #(
        .REGISTERED (REGISTERED),
        .SYN_CLASS  (SYN_CLASS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .verdict   (verdict),
        .o_undef   (out_undef),
        .o_trap2   (out_trap_el2),
        .o_trap3   (out_trap_el3),
        .o_permit  (out_permit),
        .o_miss    (out_nomatch),
        .o_syn     (out_syn_class)
    );

    generate
        if (REGISTERED) begin : g_top_chk
            // R1: foreign encoding reports a miss only
            p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && !enc_hit) |=> (out_nomatch && out_syn_class == '0));
            // R2: level 0 never reaches the register
            p_el0_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && enc_hit && req_el == 2'd0) |=> out_undef);
            // R3: level 3 always allowed
            p_el3_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && enc_hit && req_el == 2'd3) |=> out_permit);
            // R4: secure-debug priority beats everything at levels 1 and 2
            p_sdd_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && enc_hit && (req_el == 2'd1 || req_el == 2'd2) &&
                 cfg_el3_present && sdd_undef_prio && (!el3_pm_en || el3_pm_trap))
                |=> out_undef);
            // R6: EL2 trap bit never applies at level 2
            p_no_l2trap_at_el2_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && enc_hit && req_el == 2'd2) |=> !out_trap_el2);
        end
    endgenerate

endmodule

// File: tb/perfmon_uacc_trap_dec_test.sv
module perfmon_uacc_trap_dec_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    // flag vector bit positions used by the stimulus
    localparam int B_EL2EN  = 10;
    localparam int B_EL3    = 9;
    localparam int B_FGT    = 8;
    localparam int B_FGTEN  = 7;
    localparam int B_PMEN   = 6;
    localparam int B_PMTRAP = 5;
    localparam int B_L2TRAP = 4;
    localparam int B_RDN    = 3;
    localparam int B_WRN    = 2;
    localparam int B_PRIO   = 1;
    localparam int B_SDD    = 0;
    localparam logic [10:0] BASE = 11'b11111001100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_el = '0;
    logic req_write = 1'b0;
    logic [1:0] req_op0 = '0;
    logic [2:0] req_op1 = '0;
    logic [3:0] req_crn = '0;
    logic [3:0] req_crm = '0;
    logic [2:0] req_op2 = '0;
    logic [10:0] fl = '0;
    logic out_undef, out_trap_el2, out_trap_el3, out_permit, out_nomatch;
    logic [5:0] out_syn_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_code = 0;
    string exp_tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    perfmon_uacc_trap_dec uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_el(req_el),
        .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1),
        .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .cfg_el2_en(fl[B_EL2EN]), .cfg_el3_present(fl[B_EL3]),
        .cfg_fgt_present(fl[B_FGT]), .el3_fgt_en(fl[B_FGTEN]),
        .el3_pm_en(fl[B_PMEN]), .el3_pm_trap(fl[B_PMTRAP]),
        .el2_pm_trap(fl[B_L2TRAP]), .fgt_rd_n(fl[B_RDN]), .fgt_wr_n(fl[B_WRN]),
        .sdd_undef_prio(fl[B_PRIO]), .sdd_undef(fl[B_SDD]),
        .out_undef(out_undef), .out_trap_el2(out_trap_el2),
        .out_trap_el3(out_trap_el3), .out_permit(out_permit),
        .out_nomatch(out_nomatch), .out_syn_class(out_syn_class)
    );

    // behavioural reference: codes 0 none,1 undef,2 trap EL2,3 trap EL3,4 permit,5 miss
    function automatic int ref_outcome(input int el, input bit wr, input bit hit,
                                       input logic [10:0] f, output string tag);
        bit gate3;
        bit dir_n;
        if (!hit) begin tag = "R1"; return 5; end
        if (el == 0) begin tag = "R2"; return 1; end
        if (el == 3) begin tag = "R3"; return 4; end
        gate3 = f[B_EL3] && (!f[B_PMEN] || f[B_PMTRAP]);
        if (gate3 && f[B_PRIO]) begin tag = "R4"; return 1; end
        if (el == 1) begin
            dir_n = wr ? f[B_WRN] : f[B_RDN];
            if (f[B_EL2EN] && f[B_FGT] && ((f[B_EL3] && !f[B_FGTEN]) || !dir_n)) begin
                tag = "R5"; return 2;
            end
            if (f[B_EL2EN] && f[B_L2TRAP]) begin tag = "R6"; return 2; end
        end
        if (gate3) begin tag = "R7"; return f[B_SDD] ? 1 : 3; end
        tag = "R8";
        return 4;
    endfunction

    function automatic logic [4:0] code_vec(input int c);
        case (c)
            1: return 5'b10000;
            2: return 5'b01000;
            3: return 5'b00100;
            4: return 5'b00010;
            5: return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    // model state advances at every rising edge
    always @(posedge clk) begin
        string t;
        bit hit;
        if (!rst_n) begin
            exp_code = 0;
            exp_tag = "R11";
        end else if (req_valid) begin
            hit = (req_op0 == 2'b11) && (req_op1 == 3'b000) && (req_crn == 4'b1001) &&
                  (req_crm == 4'b1110) && (req_op2 == 3'b100);
            exp_code = ref_outcome(int'(req_el), req_write, hit, fl, t);
            exp_tag = t;
        end else if (exp_code != 0) begin
            exp_tag = "R10";
        end
    end

    // compare against the ports away from the active edge
    always @(negedge clk) begin
        logic [4:0] got;
        logic [4:0] want;
        logic [5:0] want_syn;
        got = {out_undef, out_trap_el2, out_trap_el3, out_permit, out_nomatch};
        want = code_vec(exp_code);
        want_syn = (exp_code == 2 || exp_code == 3) ? 6'h18 : 6'h00;
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s outcome got %b expected %b at %0t", exp_tag, got, want, $time);
        end
        checks++;
        if (out_syn_class !== want_syn) begin
            errors++;
            $display("FAIL R9 (%s) class got %h expected %h at %0t", exp_tag,
                     out_syn_class, want_syn, $time);
        end
    end

    task automatic set_enc(input int miss_fld);
        req_op0 = 2'b11; req_op1 = 3'b000; req_crn = 4'b1001;
        req_crm = 4'b1110; req_op2 = 3'b100;
        case (miss_fld)
            1: req_op0 ^= 2'b01;
            2: req_op1 ^= 3'b001;
            3: req_crn ^= 4'b0010;
            4: req_crm ^= 4'b1000;
            5: req_op2 ^= 3'b100;
            default: ;
        endcase
    endtask

    task automatic issue(input int el, input bit wr, input int miss_fld, input logic [10:0] f);
        @(negedge clk);
        req_el = 2'(el);
        req_write = wr;
        set_enc(miss_fld);
        fl = f;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R10: scramble inputs without a strobe; outputs must hold
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_el = 2'($urandom);
            req_write = 1'($urandom);
            set_enc(int'($urandom % 6));
            fl = 11'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset values observed by the compare block during reset
        // R2
        issue(0, 0, 0, BASE);
        issue(0, 1, 0, BASE);
        // R3: level 3 with every blocking control set
        issue(3, 0, 0, (BASE & ~(11'b1 << B_PMEN)) | (11'b1 << B_PRIO) | (11'b1 << B_L2TRAP));
        issue(3, 1, 0, 11'b0);
        // R8 baseline
        issue(1, 0, 0, BASE);
        issue(2, 1, 0, BASE);
        // R4 priority over a fine-grained trap and EL2 trap
        issue(1, 0, 0, (BASE & ~(11'b1 << B_PMEN) & ~(11'b1 << B_RDN)) |
                       (11'b1 << B_PRIO) | (11'b1 << B_L2TRAP));
        issue(2, 1, 0, BASE | (11'b1 << B_PMTRAP) | (11'b1 << B_PRIO));
        issue(1, 0, 0, (BASE & ~(11'b1 << B_EL3)) | (11'b1 << B_PMTRAP) | (11'b1 << B_PRIO));
        // R5 direction selects the bit
        issue(1, 0, 0, BASE & ~(11'b1 << B_RDN));
        issue(1, 1, 0, BASE & ~(11'b1 << B_RDN));
        issue(1, 1, 0, BASE & ~(11'b1 << B_WRN));
        issue(1, 0, 0, BASE & ~(11'b1 << B_FGTEN));
        issue(1, 0, 0, BASE & ~(11'b1 << B_FGT) & ~(11'b1 << B_RDN));
        issue(1, 0, 0, BASE & ~(11'b1 << B_EL2EN) & ~(11'b1 << B_RDN));
        issue(2, 0, 0, BASE & ~(11'b1 << B_RDN));
        // R5 beats R7
        issue(1, 0, 0, (BASE & ~(11'b1 << B_RDN)) | (11'b1 << B_PMTRAP));
        // R6
        issue(1, 0, 0, BASE | (11'b1 << B_L2TRAP));
        issue(2, 0, 0, BASE | (11'b1 << B_L2TRAP));
        issue(1, 0, 0, (BASE & ~(11'b1 << B_EL2EN)) | (11'b1 << B_L2TRAP));
        // R7
        issue(1, 0, 0, BASE | (11'b1 << B_PMTRAP));
        issue(1, 1, 0, BASE | (11'b1 << B_PMTRAP) | (11'b1 << B_SDD));
        issue(2, 0, 0, BASE & ~(11'b1 << B_PMEN));
        issue(2, 0, 0, (BASE & ~(11'b1 << B_PMEN)) | (11'b1 << B_SDD));
        issue(1, 0, 0, (BASE & ~(11'b1 << B_EL3)) | (11'b1 << B_PMTRAP) | (11'b1 << B_SDD));
        // R1 each field off by one bit, and at every level
        for (int k = 1; k <= 5; k++) issue(k % 4, 0, k, BASE);
        issue(3, 1, 4, 11'b0);
        // R10 hold after a trap
        issue(1, 0, 0, BASE | (11'b1 << B_PMTRAP));
        idle(12);
        // R9/R10 back-to-back strobes
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            req_el = 2'(k % 4); req_write = 1'(k / 4); set_enc(0);
            fl = BASE ^ (11'b1 << k); req_valid = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        // randomised sweep
        for (int n = 0; n < 4000; n++) begin
            issue(int'($urandom % 4), 1'($urandom), ($urandom % 4 == 0) ? int'(1 + $urandom % 5) : 0,
                  11'($urandom));
            if ($urandom % 8 == 0) idle(int'(1 + $urandom % 3));
        end
        idle(3);
        // R11: reset mid-run clears the outputs
        issue(1, 0, 0, BASE | (11'b1 << B_L2TRAP));
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule